// File: doc/BRIEF.md
# Critical-Word-First Line Fill Controller

This block handles misses for a direct-mapped instruction cache. Each line holds four 32-bit words. A core read that is marked cacheable is looked up in the array. A hit returns the stored word and makes no bus access. A miss loads the whole line from external memory, one word per beat. The first beat fetches the word the core asked for, and that word goes back to the core straight away. The other three words then follow in wrap-around order, and each one is written into the line as it arrives. A read that is not cacheable skips the array: it makes one external read, returns that word and leaves the array as it was.

Storage keeps its contents through reset. The only way to clear lines is the global invalidate input. It walks the line indices one per cycle, and the controller accepts no new request until the walk is done. The core side uses a valid/ready request and a one-cycle response pulse. The memory side holds a request and its address until a per-beat valid signal comes back.

Top module: `icache_cwf_fill`

## Requirements
- R1: A cacheable read whose line is valid with a matching tag gets `rsp_valid` and the stored word two rising edges after acceptance, and `mem_req` stays low throughout.
- R2: A cacheable miss loads all four words of the line and then marks the line valid. Later cacheable reads of any word in that line hit. A read to the same index with a different tag misses and replaces the line.
- R3: On a miss, the first beat reads the word selected by address bits [3:2]. `rsp_valid` pulses for one cycle on the edge after that beat's `mem_rvalid`, carrying that beat's data, before any further beat is taken.
- R4: After the first beat at word w, the remaining beats read words (w+1) mod 4, (w+2) mod 4 and (w+3) mod 4 of the same line, in that order.
- R5: A non-cacheable read makes exactly one beat, at the request address with bits [1:0] cleared. It returns that beat's data on the following edge and leaves the array unchanged.
- R6: Once `mem_req` rises, it stays high with a stable `mem_addr` until a cycle in which `mem_rvalid` is high.
- R7: `req_ready` falls on the edge that accepts a request. It stays low until that request is complete, including all four beats of a fill, so a request made during a fill is accepted only after the fill ends.
- R8: A one-cycle `inv_all` pulse, given while idle, holds `req_ready` low for 2^INDEX_W + 1 cycles while it clears every line. Afterwards a read to a previously cached line misses.
- R9: After reset, `req_ready` is 1 and `rsp_valid` and `mem_req` are 0. Reset does not clear cached lines: a line filled before reset still hits after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| req_valid | input | 1 | Core read request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_addr | input | ADDR_W | Byte address of the core read |
| req_cacheable | input | 1 | 1: serve through the cache; 0: bypass |
| rsp_valid | output | 1 | One-cycle pulse with the read word |
| rsp_data | output | DATA_W | Read word returned to the core |
| mem_req | output | 1 | External read beat requested |
| mem_addr | output | ADDR_W | Word-aligned address of the current beat |
| mem_rvalid | input | 1 | Current beat's data is present |
| mem_rdata | input | DATA_W | Beat data from memory |
| inv_all | input | 1 | Pulse: invalidate every line |

## Verification
Misses are started at word offsets 0, 2 and 3, and one address carries a non-zero byte offset. This shows whether the first beat follows the requested word, whether the wrap-around ends correctly, and whether the early response comes after exactly one beat. Reads of every word in a freshly filled line, plus a read to the same index with a different tag, separate true hits from stale or aliased lines. A non-cacheable read is made after the backing memory has changed, followed by a cacheable read of the same word; this distinguishes a real bypass from one that also writes the array. A request held through a fill, a full invalidate, and a reset with no invalidate show that the stall, the sweep length and the retention of lines across reset are all correct.

// File: rtl/icache_cwf_fill.sv
module icache_cwf_fill #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_cacheable,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              inv_all
);

  localparam int NLINES   = 1 << INDEX_W;
  localparam int BOFS_W   = $clog2(DATA_W / 8);
  localparam int LINE_LSB = BOFS_W + 2;
  localparam int TAG_W    = ADDR_W - LINE_LSB - INDEX_W;

  typedef enum logic [2:0] {
    S_IDLE       = 3'd0,
    S_LOOKUP     = 3'd1,
    S_FILL_FIRST = 3'd2,
    S_FILL_REST  = 3'd3,
    S_BYPASS     = 3'd4
  } state_t;

  state_t              state;
  logic [ADDR_W-1:0]   addr_q;
  logic [1:0]          beat_q;
  logic                rsp_v_q;
  logic [DATA_W-1:0]   rsp_d_q;
  logic                inv_pend;
  logic                sweep_on;
  logic [INDEX_W-1:0]  sweep_idx;

  logic [DATA_W-1:0]   line_data [NLINES*4];
  logic [TAG_W-1:0]    tag_arr   [NLINES];
  logic [NLINES-1:0]   line_vld;

  logic [INDEX_W-1:0]  idx;
  logic [TAG_W-1:0]    tag;
  logic [1:0]          wrd;
  logic [1:0]          fill_wrd;
  logic                hit;
  logic                filling;
  logic                last_beat;

  assign idx       = addr_q[LINE_LSB +: INDEX_W];
  assign tag       = addr_q[ADDR_W-1 -: TAG_W];
  assign wrd       = addr_q[BOFS_W +: 2];
  assign fill_wrd  = wrd + beat_q;
  assign hit       = line_vld[idx] && (tag_arr[idx] == tag);
  assign filling   = (state == S_FILL_FIRST) || (state == S_FILL_REST);
  assign last_beat = (state == S_FILL_REST) && (beat_q == 2'd3);

  assign req_ready = (state == S_IDLE) && !inv_pend && !sweep_on;
  assign mem_req   = filling || (state == S_BYPASS);
  assign mem_addr  = (state == S_BYPASS)
                   ? {addr_q[ADDR_W-1:BOFS_W], {BOFS_W{1'b0}}}
                   : {addr_q[ADDR_W-1:LINE_LSB], fill_wrd, {BOFS_W{1'b0}}};
  assign rsp_valid = rsp_v_q;
  assign rsp_data  = rsp_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      addr_q    <= '0;
      beat_q    <= '0;
      rsp_v_q   <= 1'b0;
      rsp_d_q   <= '0;
      inv_pend  <= 1'b0;
      sweep_on  <= 1'b0;
      sweep_idx <= '0;
    end else begin
      rsp_v_q <= 1'b0;

      if (sweep_on) begin
        sweep_idx <= sweep_idx + 1'b1;
        if (sweep_idx == INDEX_W'(NLINES - 1)) sweep_on <= 1'b0;
      end else if (inv_pend && state == S_IDLE) begin
        sweep_on  <= 1'b1;
        sweep_idx <= '0;
        inv_pend  <= 1'b0;
      end
      if (inv_all) inv_pend <= 1'b1;

      case (state)
        S_IDLE: begin
          if (req_valid && req_ready) begin
            addr_q <= req_addr;
            state  <= req_cacheable ? S_LOOKUP : S_BYPASS;
          end
        end
        S_LOOKUP: begin
          if (hit) begin
            rsp_v_q <= 1'b1;
            rsp_d_q <= line_data[{idx, wrd}];
            state   <= S_IDLE;
          end else begin
            beat_q <= 2'd0;
            state  <= S_FILL_FIRST;
          end
        end
        S_FILL_FIRST: begin
          if (mem_rvalid) begin
            rsp_v_q <= 1'b1;
            rsp_d_q <= mem_rdata;
            beat_q  <= 2'd1;
            state   <= S_FILL_REST;
          end
        end
        S_FILL_REST: begin
          if (mem_rvalid) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == 2'd3) state <= S_IDLE;
          end
        end
        S_BYPASS: begin
          if (mem_rvalid) begin
            rsp_v_q <= 1'b1;
            rsp_d_q <= mem_rdata;
            state   <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (sweep_on) begin
      line_vld[sweep_idx] <= 1'b0;
    end else if (filling && mem_rvalid) begin
      line_data[{idx, fill_wrd}] <= mem_rdata;
      if (state == S_FILL_FIRST) begin
        tag_arr[idx]  <= tag;
        line_vld[idx] <= 1'b0;
      end
      if (last_beat) line_vld[idx] <= 1'b1;
    end
  end

endmodule

// File: rtl/icache_cwf_fill_chk.sv
module icache_cwf_fill_chk #(
  parameter int ADDR_W = 32,
  parameter int BOFS_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_cacheable,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rvalid,
  input logic [2:0]        st,
  input logic              sweep_on
);

  localparam logic [2:0] ST_IDLE = 3'd0;
  localparam logic [2:0] ST_REST = 3'd3;

  // R6
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

  // R4
  wrap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REST) && $past(mem_req && mem_rvalid) |->
      (mem_addr[BOFS_W +: 2] == 2'($past(mem_addr[BOFS_W +: 2]) + 2'd1)) &&
      (mem_addr[ADDR_W-1:BOFS_W+2] == $past(mem_addr[ADDR_W-1:BOFS_W+2])));

  // R5
  bypass_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_cacheable |=>
      mem_req && (mem_addr == {$past(req_addr[ADDR_W-1:BOFS_W]), {BOFS_W{1'b0}}}));

  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R3
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8
  sweep_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_on |-> (st == ST_IDLE) && !mem_req);

endmodule

bind icache_cwf_fill icache_cwf_fill_chk #(.ADDR_W(ADDR_W), .BOFS_W(BOFS_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_cacheable(req_cacheable),
  .req_addr     (req_addr),
  .rsp_valid    (rsp_valid),
  .mem_req      (mem_req),
  .mem_addr     (mem_addr),
  .mem_rvalid   (mem_rvalid),
  .st           (state),
  .sweep_on     (sweep_on)
);

// File: tb/tb_icache_cwf_fill.sv
module tb_icache_cwf_fill;
  localparam int INDEX_W = 4;
  localparam int NLINES  = 1 << INDEX_W;
  localparam int LAT     = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_cacheable = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        inv_all = 1'b0;

  int checks = 0;
  int errors = 0;
  int nbeats = 0;
  logic [31:0] beat_log [64];
  logic [31:0] gen = 32'h0;
  bit finished = 0;

  always #4 clk = ~clk;

  icache_cwf_fill #(.ADDR_W(32), .DATA_W(32), .INDEX_W(INDEX_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_cacheable(req_cacheable),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .inv_all(inv_all)
  );

  function automatic logic [31:0] mdata(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[31:16] ^ a[15:0]} ^ gen;
  endfunction

  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_rvalid) begin
        mem_rvalid = 1'b0;
        cnt = 0;
      end else if (mem_req) begin
        if (cnt == LAT) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mdata(mem_addr);
          if (nbeats < 64) beat_log[nbeats] = mem_addr;
          nbeats++;
        end else cnt++;
      end else cnt = 0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    int g = 0;
    while (!req_ready && g < 500) begin @(negedge clk); g++; end
  endtask

  task automatic do_read(input logic [31:0] a, input logic c, output logic [31:0] d,
                         output int lat, output int nb_rsp);
    int g = 0;
    @(negedge clk);
    wait_ready();
    req_valid = 1'b1; req_addr = a; req_cacheable = c;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 500) begin @(negedge clk); lat++; end
    d = rsp_data;
    nb_rsp = nbeats;
    wait_ready();
    g = g;
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    check("R9 req_ready after reset", 32'(req_ready), 32'd1);
    check("R9 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    check("R9 mem_req after reset", 32'(mem_req), 32'd0);
  endtask

  task automatic t_invalidate();
    int lows = 0;
    @(negedge clk); wait_ready();
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    while (!req_ready && lows < 500) begin lows++; @(negedge clk); end
    check("R8 invalidate busy cycles", 32'(lows), 32'(NLINES + 1));
  endtask

  task automatic t_miss(input logic [31:0] a, input string tag);
    logic [31:0] d; int lat, nb_rsp;
    int b0 = nbeats;
    logic [1:0] w = a[3:2];
    do_read(a, 1'b1, d, lat, nb_rsp);
    check({"R3 miss data ", tag}, d, mdata({a[31:2], 2'b00}));
    check({"R3 one beat before response ", tag}, 32'(nb_rsp - b0), 32'd1);
    check({"R2 four beats per fill ", tag}, 32'(nbeats - b0), 32'd4);
    for (int k = 0; k < 4; k++)
      check({"R4 beat order ", tag}, beat_log[b0 + k], {a[31:4], 2'(w + 2'(k)), 2'b00});
  endtask

  task automatic t_line_hits(input logic [31:0] base, input string tag);
    logic [31:0] d; int lat, nb_rsp;
    for (int k = 0; k < 4; k++) begin
      int b0 = nbeats;
      logic [31:0] a = {base[31:4], 2'(k), 2'b00};
      do_read(a, 1'b1, d, lat, nb_rsp);
      check({"R1 hit data ", tag}, d, mdata(a));
      check({"R1 hit latency ", tag}, 32'(lat), 32'd1);
      check({"R1 R2 hit makes no beat ", tag}, 32'(nbeats - b0), 32'd0);
    end
  endtask

  task automatic t_bypass();
    logic [31:0] d; int lat, nb_rsp;
    int b0;
    logic [31:0] a = 32'h0002_0076;
    logic [31:0] old_v = mdata(32'h0002_0074);
    gen = 32'hFFFF_0000;
    b0 = nbeats;
    do_read(a, 1'b0, d, lat, nb_rsp);
    check("R5 bypass data", d, mdata(32'h0002_0074));
    check("R5 bypass single beat", 32'(nbeats - b0), 32'd1);
    check("R5 bypass aligned address", beat_log[b0], 32'h0002_0074);
    b0 = nbeats;
    do_read(32'h0002_0074, 1'b1, d, lat, nb_rsp);
    check("R5 array unchanged after bypass", d, old_v);
    check("R5 cached read after bypass no beat", 32'(nbeats - b0), 32'd0);
    gen = 32'h0;
  endtask

  task automatic t_stall();
    int b0 = nbeats;
    int g = 0;
    @(negedge clk); wait_ready();
    req_valid = 1'b1; req_addr = 32'h0004_0010; req_cacheable = 1'b1;
    @(negedge clk);
    req_addr = 32'h0002_0078;
    while (!rsp_valid && g < 500) begin @(negedge clk); g++; end
    check("R7 miss word early", rsp_data, mdata(32'h0004_0010));
    check("R7 ready low mid fill", 32'(req_ready), 32'd0);
    check("R3 response after first beat", 32'(nbeats - b0), 32'd1);
    g = 0;
    while (!req_ready && g < 500) begin @(negedge clk); g++; end
    check("R7 fill completes before next accept", 32'(nbeats - b0), 32'd4);
    @(negedge clk);
    req_valid = 1'b0;
    g = 0;
    while (!rsp_valid && g < 500) begin @(negedge clk); g++; end
    check("R7 stalled request served", rsp_data, mdata(32'h0002_0078));
    check("R7 stalled hit no beat", 32'(nbeats - b0), 32'd4);
    wait_ready();
  endtask

  task automatic t_conflict();
    logic [31:0] d; int lat, nb_rsp;
    int b0;
    t_miss(32'h0005_2344, "conflict");
    b0 = nbeats;
    do_read(32'h0001_2348, 1'b1, d, lat, nb_rsp);
    check("R2 evicted line misses", 32'(nbeats - b0), 32'd4);
    check("R2 evicted line refetched data", d, mdata(32'h0001_2348));
  endtask

  task automatic t_inv_effect();
    logic [31:0] d; int lat, nb_rsp;
    int b0;
    t_invalidate();
    b0 = nbeats;
    do_read(32'h0003_00AE, 1'b1, d, lat, nb_rsp);
    check("R8 line misses after invalidate", 32'(nbeats - b0), 32'd4);
  endtask

  task automatic t_reset_keep();
    logic [31:0] d; int lat, nb_rsp;
    int b0;
    pulse_reset();
    t_reset_state();
    b0 = nbeats;
    do_read(32'h0003_00AC, 1'b1, d, lat, nb_rsp);
    check("R9 line kept through reset", d, mdata(32'h0003_00AC));
    check("R9 hit after reset no beat", 32'(nbeats - b0), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_invalidate();
    t_miss(32'h0001_2348, "w2");
    t_line_hits(32'h0001_2340, "w2 line");
    t_miss(32'h0002_0070, "w0");
    t_miss(32'h0003_00AE, "w3");
    t_line_hits(32'h0003_00A0, "w3 line");
    t_bypass();
    t_stall();
    t_conflict();
    t_inv_effect();
    t_reset_keep();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
    end
  end
endmodule